// File: doc/BRIEF.md
# Card Activation Sequencer

This block brings up the contacts of a smart card when a host asks for a session, and takes them down again in order. A falling edge on the active-low session command starts activation. From that edge, a time base counts pulses of a slow internal oscillator in units of `UNIT_TICKS` pulses. The supply generator turns on at once. A supply-stable flag follows one and a half units later, the data lines at four units, and the session is declared active at seven units. Card reset stays low until that seventh unit and then simply mirrors the host reset input.

The clock start has two forms, chosen by the host reset level sampled at the start edge. If that level is low, the card clock turns on with the data lines. If it is high, the clock waits until the host pulls its reset input low inside the window from the data-line milestone up to, but not including, the active milestone. If the host never does so, the clock stays off for the whole session. Once the session is active, the host reset input no longer touches the clock.

Raising the command or losing the supervised supply during activation or a session starts a shutdown. Card reset drops at once, the clock stops one unit later, the data lines one unit after that, and the supply one unit after that. The block then returns to idle. The analog supply ramp and the clock divider lie outside.

Top module: `card_act_seq`

## Requirements
- R1: After reset, supply_en, vcc_ok, io_en, clk_en, card_rst and active are all 0.
- R2: In idle with supply_ok high, a falling edge of cmd_n sampled at a clock edge sets supply_en at that edge. A falling edge while supply_ok is low is ignored.
- R3: vcc_ok rises at the edge that counts the 1.5×UNIT_TICKS-th osc_tick after the start edge (tick 96 by default).
- R4: io_en rises at the edge of osc_tick 4×UNIT_TICKS (tick 256).
- R5: If host_rst was low at the start edge, clk_en rises together with io_en.
- R6: If host_rst was high at the start edge, clk_en rises at the first edge from tick 256 through tick 447 at which host_rst is sampled low. It rises at tick 256 if host_rst went low earlier. If no such edge occurs, clk_en stays 0 for the session.
- R7: active rises at the edge of osc_tick 7×UNIT_TICKS (tick 448). card_rst is 0 before that and equals host_rst afterwards. While active, host_rst changes leave clk_en unchanged.
- R8: With cmd_n high or supply_ok low during activation or an active session, the next edge clears active and card_rst. Counting ticks from that edge, clk_en clears at tick UNIT_TICKS, io_en at tick 2×UNIT_TICKS, and supply_en and vcc_ok at tick 3×UNIT_TICKS.
- R9: A falling cmd_n outside idle is ignored, and a cmd_n still low on return to idle starts nothing. A new session needs a fresh falling edge in idle.
- R10: All timing counts osc_tick pulses only; clock cycles without osc_tick advance no milestone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_n | input | 1 | Session command, active low |
| host_rst | input | 1 | Host reset input; clock gate before the session, card reset source during it |
| supply_ok | input | 1 | Supervised supply is above threshold |
| osc_tick | input | 1 | One-cycle pulse per internal oscillator period |
| supply_en | output | 1 | Card supply generator enable |
| vcc_ok | output | 1 | Card supply ramp complete |
| io_en | output | 1 | Data line enable |
| clk_en | output | 1 | Card clock enable |
| card_rst | output | 1 | Card reset contact level |
| active | output | 1 | Session active |

## Verification
The hardest situations to reach are the edges of the host-controlled clock window. A host reset released on the last tick before the active milestone must start the clock, and one released on that milestone's tick must not. A falling command that arrives during shutdown is a second hard case. The bench reaches both by driving osc_tick one pulse at a time and counting pulses from the start edge. Each release is placed on an exact tick number taken from a vector table. A command fall is injected in the middle of a shutdown, and idle is then held with the command still low.

// File: rtl/cas_pkg.sv
package cas_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACT   = 2'd1,
    ST_ON    = 2'd2,
    ST_DEACT = 2'd3
  } seq_state_e;

  // The time base counts half units; 4 bits cover the longest phase (14 half units)
  localparam int unsigned HU_W = 4;

  // Activation milestones, given as the half-unit count just before the milestone
  localparam logic [HU_W-1:0] HU_RAMP_PRE  = 4'd2;   // supply stable at 1.5 units
  localparam logic [HU_W-1:0] HU_IO_PRE    = 4'd7;   // data lines at 4 units
  localparam logic [HU_W-1:0] HU_IO        = 4'd8;   // clock window opens
  localparam logic [HU_W-1:0] HU_ON_PRE    = 4'd13;  // session active at 7 units

  // Shutdown milestones, one unit apart
  localparam logic [HU_W-1:0] HU_CLKOFF_PRE = 4'd1;
  localparam logic [HU_W-1:0] HU_IOOFF_PRE  = 4'd3;
  localparam logic [HU_W-1:0] HU_VCCOFF_PRE = 4'd5;

endpackage

// File: rtl/cas_timebase.sv
module cas_timebase
  import cas_pkg::*;
#(
  parameter int unsigned UNIT_TICKS = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            run,
  input  logic            osc_tick,
  output logic            step,
  output logic [HU_W-1:0] hu
);

  localparam int unsigned HALF = UNIT_TICKS / 2;
  localparam int unsigned TW   = (HALF > 2) ? $clog2(HALF) : 1;

  logic            adv;
  logic [HU_W-1:0] hu_q, hu_d;

  assign adv = run & osc_tick;

  generate
    if (HALF > 1) begin : g_div
      logic [TW-1:0] tcnt_q, tcnt_d;
      logic          wrap;

      assign wrap = (tcnt_q == TW'(HALF - 1));

      always_comb begin
        tcnt_d = tcnt_q;
        if (clear)    tcnt_d = '0;
        else if (adv) tcnt_d = wrap ? '0 : tcnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tcnt_q <= '0;
        else        tcnt_q <= tcnt_d;
      end

      assign step = adv & wrap;
    end else begin : g_nodiv
      assign step = adv;
    end
  endgenerate

  always_comb begin
    hu_d = hu_q;
    if (clear)     hu_d = '0;
    else if (step) hu_d = hu_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hu_q <= '0;
    else        hu_q <= hu_d;
  end

  assign hu = hu_q;

  // Without an oscillator pulse the half-unit count cannot move unless cleared
  p_no_tick_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_tick && !clear) |=> $stable(hu_q));

endmodule

// File: rtl/cas_seq.sv
module cas_seq
  import cas_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_n,
  input  logic            supply_ok,
  input  logic            step,
  input  logic [HU_W-1:0] hu,
  output seq_state_e      state,
  output logic            start,
  output logic            abort,
  output logic            done,
  output logic            off_done,
  output logic            clear,
  output logic            run
);

  seq_state_e state_q, state_d;
  logic       cmd_q;
  logic       cmd_fall;
  logic       live;

  assign cmd_fall = cmd_q & ~cmd_n;
  assign live     = (state_q == ST_ACT) | (state_q == ST_ON);

  assign start    = (state_q == ST_IDLE) & cmd_fall & supply_ok;
  assign abort    = live & (cmd_n | ~supply_ok);
  assign done     = (state_q == ST_ACT) & ~abort & step & (hu == HU_ON_PRE);
  assign off_done = (state_q == ST_DEACT) & step & (hu == HU_VCCOFF_PRE);
  assign clear    = start | abort;
  assign run      = (state_q == ST_ACT) | (state_q == ST_DEACT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start)    state_d = ST_ACT;
      ST_ACT:   if (abort)    state_d = ST_DEACT;
                else if (done) state_d = ST_ON;
      ST_ON:    if (abort)    state_d = ST_DEACT;
      ST_DEACT: if (off_done) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_n;
    end
  end

  assign state = state_q;

  // Shutdown only ever ends in idle, never goes back to a session
  p_deact_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEACT) |=> (state_q == ST_DEACT || state_q == ST_IDLE));

  // A session is entered only from idle
  p_act_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_ACT) |-> $past(state_q == ST_IDLE));

endmodule

// File: rtl/cas_drive.sv
module cas_drive
  import cas_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  seq_state_e      state,
  input  logic            step,
  input  logic [HU_W-1:0] hu,
  input  logic            start,
  input  logic            abort,
  input  logic            done,
  input  logic            off_done,
  input  logic            host_rst,
  output logic            supply_en,
  output logic            vcc_ok,
  output logic            io_en,
  output logic            clk_en,
  output logic            card_rst,
  output logic            active
);

  logic sup_q, sup_d;
  logic rmp_q, rmp_d;
  logic io_q,  io_d;
  logic ck_q,  ck_d;
  logic act_q, act_d;
  logic hold_q, hold_d;

  logic in_act, in_deact;
  logic ramp_set, io_set, win, clk_set;
  logic clk_clr, io_clr;

  assign in_act   = (state == ST_ACT) & ~abort;
  assign in_deact = (state == ST_DEACT);

  assign ramp_set = in_act & step & (hu == HU_RAMP_PRE);
  assign io_set   = in_act & step & (hu == HU_IO_PRE);
  // Host-controlled clock window: from the data-line milestone up to the active milestone
  assign win      = in_act & ~done & ((hu >= HU_IO) | io_set);
  assign clk_set  = (io_set & ~hold_q) | (win & hold_q & ~host_rst);

  assign clk_clr  = in_deact & step & (hu == HU_CLKOFF_PRE);
  assign io_clr   = in_deact & step & (hu == HU_IOOFF_PRE);

  always_comb begin
    sup_d  = sup_q;
    rmp_d  = rmp_q;
    io_d   = io_q;
    ck_d   = ck_q;
    act_d  = act_q;
    hold_d = hold_q;
    if (start) begin
      sup_d  = 1'b1;
      hold_d = host_rst;
    end
    if (ramp_set) rmp_d = 1'b1;
    if (io_set)   io_d  = 1'b1;
    if (clk_set)  ck_d  = 1'b1;
    if (done)     act_d = 1'b1;
    if (abort)    act_d = 1'b0;
    if (clk_clr)  ck_d  = 1'b0;
    if (io_clr)   io_d  = 1'b0;
    if (off_done) begin
      sup_d = 1'b0;
      rmp_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_q  <= 1'b0;
      rmp_q  <= 1'b0;
      io_q   <= 1'b0;
      ck_q   <= 1'b0;
      act_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      sup_q  <= sup_d;
      rmp_q  <= rmp_d;
      io_q   <= io_d;
      ck_q   <= ck_d;
      act_q  <= act_d;
      hold_q <= hold_d;
    end
  end

  assign supply_en = sup_q;
  assign vcc_ok    = rmp_q;
  assign io_en     = io_q;
  assign clk_en    = ck_q;
  assign active    = act_q;
  assign card_rst  = act_q & host_rst;

  p_ramp_in_supply_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_ok |-> supply_en);

  p_io_in_supply_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> supply_en);

  p_clk_in_io_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> io_en);

  p_rst_only_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> active);

  p_clk_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(clk_en));

  p_abort_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!active && !card_rst));

endmodule

// File: rtl/card_act_seq.sv
module card_act_seq
  import cas_pkg::*;
#(
  parameter int unsigned UNIT_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_n,
  input  logic host_rst,
  input  logic supply_ok,
  input  logic osc_tick,
  output logic supply_en,
  output logic vcc_ok,
  output logic io_en,
  output logic clk_en,
  output logic card_rst,
  output logic active
);

  seq_state_e      state;
  logic            step;
  logic [HU_W-1:0] hu;
  logic            start, abort, done, off_done, clear, run;

  cas_timebase #(.UNIT_TICKS(UNIT_TICKS)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .run      (run),
    .osc_tick (osc_tick),
    .step     (step),
    .hu       (hu)
  );

  cas_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_n     (cmd_n),
    .supply_ok (supply_ok),
    .step      (step),
    .hu        (hu),
    .state     (state),
    .start     (start),
    .abort     (abort),
    .done      (done),
    .off_done  (off_done),
    .clear     (clear),
    .run       (run)
  );

  cas_drive u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .step      (step),
    .hu        (hu),
    .start     (start),
    .abort     (abort),
    .done      (done),
    .off_done  (off_done),
    .host_rst  (host_rst),
    .supply_en (supply_en),
    .vcc_ok    (vcc_ok),
    .io_en     (io_en),
    .clk_en    (clk_en),
    .card_rst  (card_rst),
    .active    (active)
  );

  // Supply only turns on from a start in idle, with the supervisor good
  p_start_needs_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_en) |-> $past(supply_ok && state == ST_IDLE));

endmodule

// File: tb/card_act_seq_test.sv
`timescale 1ns/1ps
module card_act_seq_test;

  logic clk = 1'b0;
  logic rst_n, cmd_n, host_rst, supply_ok, osc_tick;
  logic supply_en, vcc_ok, io_en, clk_en, card_rst, active;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  card_act_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .host_rst(host_rst),
    .supply_ok(supply_ok), .osc_tick(osc_tick),
    .supply_en(supply_en), .vcc_ok(vcc_ok), .io_en(io_en),
    .clk_en(clk_en), .card_rst(card_rst), .active(active)
  );

  // {host_rst at start, tick at which host_rst goes low (0 = never), expected clock tick (0 = never)}
  localparam int NV = 7;
  localparam int VEC [NV][3] = '{
    '{0,   0, 256},
    '{1, 300, 300},
    '{1, 100, 256},
    '{1,   0,   0},
    '{1, 447, 447},
    '{1, 448,   0},
    '{1, 256, 256}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock edge with the given tick level; returns at the following falling edge
  task automatic step(input logic t);
    osc_tick = t;
    @(posedge clk);
    @(negedge clk);
    osc_tick = 1'b0;
  endtask

  task automatic activate(input logic init, input int drop, input int exp_clk, input int idx);
    int f_vcc = 0, f_io = 0, f_clk = 0, f_act = 0;
    int rst_bad = 0;
    logic c0;
    host_rst = init;
    cmd_n = 1'b0;
    step(1'b0);
    chk($sformatf("R2 vec%0d supply_en at start", idx), supply_en, 1);
    for (int n = 1; n <= 448; n++) begin
      if (n == drop) host_rst = 1'b0;
      step(1'b1);
      if (vcc_ok && f_vcc == 0) f_vcc = n;
      if (io_en  && f_io  == 0) f_io  = n;
      if (clk_en && f_clk == 0) f_clk = n;
      if (active && f_act == 0) f_act = n;
      if (card_rst !== (active & host_rst)) rst_bad++;
    end
    chk($sformatf("R3 vec%0d vcc_ok tick", idx), f_vcc, 96);
    chk($sformatf("R4 vec%0d io_en tick", idx), f_io, 256);
    chk($sformatf("R5/R6 vec%0d clk_en tick", idx), f_clk, exp_clk);
    chk($sformatf("R7 vec%0d active tick", idx), f_act, 448);
    chk($sformatf("R7 vec%0d card_rst tracking errors", idx), rst_bad, 0);
    c0 = clk_en;
    host_rst = 1'b1;
    step(1'b1);
    chk($sformatf("R7 vec%0d card_rst follows high", idx), card_rst, 1);
    chk($sformatf("R7 vec%0d clk_en frozen", idx), clk_en, c0);
    host_rst = 1'b0;
    step(1'b1);
    chk($sformatf("R7 vec%0d card_rst follows low", idx), card_rst, 0);
    chk($sformatf("R7 vec%0d clk_en frozen", idx), clk_en, c0);
  endtask

  task automatic deactivate(input bit by_supply, input logic exp_clk, input logic exp_io,
                            input int fall_at, input string tag);
    int bad = 0;
    if (by_supply) supply_ok = 1'b0;
    else           cmd_n = 1'b1;
    step(1'b0);
    supply_ok = 1'b1;
    chk({"R8 ", tag, " active cleared"}, active, 0);
    chk({"R8 ", tag, " card_rst cleared"}, card_rst, 0);
    for (int n = 1; n <= 192; n++) begin
      if (n == fall_at) cmd_n = 1'b0;
      step(1'b1);
      if (clk_en    !== (exp_clk & (n < 64)))  bad++;
      if (io_en     !== (exp_io  & (n < 128))) bad++;
      if (supply_en !== (n < 192))             bad++;
      if (n == 192 && vcc_ok !== 1'b0)         bad++;
    end
    chk({"R8 ", tag, " shutdown order errors"}, bad, 0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_n = 1'b1; host_rst = 1'b0; supply_ok = 1'b1; osc_tick = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 supply_en", supply_en, 0);
    chk("R1 vcc_ok", vcc_ok, 0);
    chk("R1 io_en", io_en, 0);
    chk("R1 clk_en", clk_en, 0);
    chk("R1 card_rst", card_rst, 0);
    chk("R1 active", active, 0);
    rst_n = 1'b1;
    step(1'b0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      activate(VEC[v][0][0], VEC[v][1], VEC[v][2], v);
      deactivate(1'b0, (VEC[v][2] != 0), 1'b1, 0, $sformatf("vec%0d", v));
      host_rst = 1'b0;
      step(1'b0);
    end

    // R2: fall while supervisor bad is ignored, and no late start once it recovers
    supply_ok = 1'b0;
    cmd_n = 1'b0;
    step(1'b0);
    chk("R2 fall with supply low ignored", supply_en, 0);
    supply_ok = 1'b1;
    step(1'b1);
    step(1'b1);
    chk("R2 no start without new fall", supply_en, 0);
    cmd_n = 1'b1;
    step(1'b0);

    // R10: cycles without osc_tick do not advance timing
    cmd_n = 1'b0;
    step(1'b0);
    for (int n = 1; n <= 95; n++) step(1'b1);
    for (int n = 0; n < 40; n++) step(1'b0);
    chk("R10 vcc_ok held without ticks", vcc_ok, 0);
    step(1'b1);
    chk("R10 vcc_ok on 96th tick", vcc_ok, 1);

    // R8/R9: supply loss mid-activation, then command still low in idle
    for (int n = 97; n <= 200; n++) step(1'b1);
    deactivate(1'b1, 1'b0, 1'b0, 0, "supply loss");
    step(1'b1);
    step(1'b1);
    chk("R9 low command after shutdown starts nothing", supply_en, 0);
    cmd_n = 1'b1;
    step(1'b0);

    // R9: fall during shutdown ignored; fresh fall in idle starts
    cmd_n = 1'b0;
    step(1'b0);
    for (int n = 1; n <= 300; n++) step(1'b1);
    deactivate(1'b0, 1'b1, 1'b1, 50, "cmd abort");
    step(1'b1);
    step(1'b1);
    chk("R9 fall during shutdown ignored", supply_en, 0);
    cmd_n = 1'b1;
    step(1'b0);
    cmd_n = 1'b0;
    step(1'b0);
    chk("R9 fresh fall in idle starts", supply_en, 1);
    cmd_n = 1'b1;
    step(1'b0);
    chk("R8 early abort active", active, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule